// File: doc/BRIEF.md
# Branch, Call and Stack Control Unit

This block resolves the program-flow instructions of an 8-bit processor. When `start` is pulsed, it captures a control-flow opcode, its operand bytes, the current program counter, stack pointer, the HL pair, the pair to be pushed, and the zero and carry flags. It then works out the next program counter and stack pointer. Stack traffic goes one byte per cycle through a plain memory port whose read data is combinational.

`pcIn` is the address of the byte that follows the opcode, so the first operand byte sits there. The unit covers these instructions:
- absolute jumps, conditional and unconditional
- jumps through HL
- signed 8-bit relative jumps
- calls, conditional and unconditional
- pushes and pops of register pairs
- the two instructions that clear and set the interrupt master enable

Each instruction ends with a one-cycle `done` pulse. The result outputs hold their values between pulses.

Top module: `flowCtrlUnit`

## Requirements
- R1: During and after reset, before any instruction completes: `pcOut`=0x0000, `spOut`=0x0000, `pairOut`=0x0000, `ime`=1, `done`=0, `memWe`=0, `memRe`=0.
- R2: Opcode 0xC3 loads `pcOut` with the little-endian target {`operandHi`,`operandLo`}. `done` rises two cycles after the start cycle.
- R3: The conditional jumps test bits [4:3] of the opcode: 0=zero clear, 1=zero set, 2=carry clear, 3=carry set. The opcodes are 0xC2, 0xCA, 0xD2 and 0xDA. When taken, the target is loaded. When not taken, `pcOut`=`pcIn`+2.
- R4: Opcode 0xE9 loads `pcOut` from `hlIn`.
- R5: Opcode 0x18, and 0x20/0x28/0x30/0x38 with the same condition field, give `pcIn`+1+sign-extended `operandLo` when taken. When not taken they give `pcIn`+1.
- R6: A taken call writes a return address of `pcIn`+2 as two bytes. The high byte goes to `spIn`-1 first and the low byte to `spIn`-2 next. Then `spOut`=`spIn`-2 and `pcOut`=target. The unconditional call is 0xCD, and the conditional calls are 0xC4/0xCC/0xD4/0xDC with the R3 field. `done` rises four cycles after start.
- R7: A call that is not taken makes no memory access, gives `pcOut`=`pcIn`+2, leaves `spOut`=`spIn`, and completes in two cycles.
- R8: Push (opcodes 0xC5/0xD5/0xE5/0xF5) writes `pairIn`[15:8] to `spIn`-1 and then `pairIn`[7:0] to `spIn`-2. It gives `spOut`=`spIn`-2 and `pcOut`=`pcIn`.
- R9: Pop (opcodes 0xC1/0xD1/0xE1/0xF1) reads the low byte at `spIn` and then the high byte at `spIn`+1. It gives `pairOut` = {high, low} and `spOut`=`spIn`+2.
- R10: Opcode 0xF3 clears `ime` and 0xFB sets it. `ime` changes only at completion.
- R11: All program-counter, stack-pointer and stack-address arithmetic wraps modulo 2^16.
- R12: `done` lasts one cycle, and the result outputs change only when it rises. `start` is ignored while an instruction is in flight. Any other opcode completes with `pcOut`=`pcIn` and `spOut`=`spIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction; inputs are captured this cycle |
| opcode | input | 8 | Control-flow opcode |
| operandLo | input | 8 | First operand byte (low target byte or offset) |
| operandHi | input | 8 | Second operand byte (high target byte) |
| pcIn | input | 16 | Address of the byte after the opcode |
| spIn | input | 16 | Current stack pointer |
| hlIn | input | 16 | Current HL pair |
| pairIn | input | 16 | Register pair to push |
| flagZ | input | 1 | Zero flag |
| flagC | input | 1 | Carry flag |
| memRdata | input | 8 | Combinational read data for `memAddr` |
| done | output | 1 | One-cycle completion strobe |
| pcOut | output | 16 | Next program counter |
| spOut | output | 16 | Next stack pointer |
| pairOut | output | 16 | Pair assembled by the last pop |
| ime | output | 1 | Interrupt master enable |
| memWe | output | 1 | Byte write strobe |
| memRe | output | 1 | Byte read strobe |
| memAddr | output | 16 | Byte address |
| memWdata | output | 8 | Byte write data |

## Verification
A wrongly decoded condition field shows up as a wrong `pcOut` at the `done` cycle, two cycles after start. The same check also catches wrong offset sign extension. A stack-pointer arithmetic error appears earlier, on `memAddr` during the first write or read cycle, one cycle before the second access; the final `spOut` then confirms it. A wrong return-address source or byte order appears in the write data of the very first write cycle. A sequencing error appears as an extra or missing access, or as `done` arriving at the wrong cycle.

// File: rtl/fcPkg.sv
`timescale 1ns/1ps
package fcPkg;
  localparam int OPW = 8;

  typedef enum logic [2:0] {PC_HOLD, PC_SKIP1, PC_SKIP2, PC_ABS, PC_HL, PC_REL} pcSelT;
  typedef enum logic [1:0] {AD_SPM1, AD_SPM2, AD_SP, AD_SPP1} adSelT;
  typedef enum logic [2:0] {S_IDLE, S_EXEC, S_WR1, S_WR2, S_RD1, S_RD2} fcStateT;

  typedef struct packed {
    logic  latchIn;   // capture instruction and context
    logic  commitPc;  // update pc/sp/ime outputs (end of instruction)
    pcSelT pcSel;
    logic  spDown;    // sp - 2 at commit
    logic  spUp;      // sp + 2 at commit
    adSelT adSel;
    logic  memWr;
    logic  memRd;
    logic  wrHi;      // write the high byte of the word source
    logic  pushRet;   // word source is the return address, else the pair
    logic  capLo;     // hold the byte read at sp
    logic  capHi;     // assemble the popped pair
    logic  imeSet;
    logic  imeClr;
  } ctrlStrobeT;
endpackage

// File: rtl/fcControl.sv
`timescale 1ns/1ps
module fcControl
  import fcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [OPW-1:0]   opQ,
  input  logic             zQ,
  input  logic             cQ,
  output ctrlStrobeT       st,
  output logic             done
);
  fcStateT state, nextState;
  logic    callQ, callNext;

  logic isJpAbs, isJpCc, isJpHl, isJr, isJrCc, isCall, isCallCc, isPush, isPop, isDi, isEi;
  logic condOk;

  always_comb begin
    isJpAbs  = (opQ == 8'hC3);
    isJpCc   = (opQ[7:5] == 3'b110) && (opQ[2:0] == 3'b010);
    isJpHl   = (opQ == 8'hE9);
    isJr     = (opQ == 8'h18);
    isJrCc   = (opQ[7:5] == 3'b001) && (opQ[2:0] == 3'b000);
    isCall   = (opQ == 8'hCD);
    isCallCc = (opQ[7:5] == 3'b110) && (opQ[2:0] == 3'b100);
    isPush   = (opQ[7:6] == 2'b11) && (opQ[3:0] == 4'h5);
    isPop    = (opQ[7:6] == 2'b11) && (opQ[3:0] == 4'h1);
    isDi     = (opQ == 8'hF3);
    isEi     = (opQ == 8'hFB);
    case (opQ[4:3])
      2'd0:    condOk = !zQ;
      2'd1:    condOk = zQ;
      2'd2:    condOk = !cQ;
      default: condOk = cQ;
    endcase
  end

  always_comb begin
    st        = '0;
    st.pcSel  = PC_HOLD;
    st.adSel  = AD_SP;
    nextState = state;
    callNext  = callQ;
    case (state)
      S_IDLE: begin
        if (start) begin
          st.latchIn = 1'b1;
          nextState  = S_EXEC;
        end
      end
      S_EXEC: begin
        nextState = S_IDLE;
        if (isJpAbs || isJpCc) begin
          st.commitPc = 1'b1;
          st.pcSel    = (isJpAbs || condOk) ? PC_ABS : PC_SKIP2;
        end else if (isJpHl) begin
          st.commitPc = 1'b1;
          st.pcSel    = PC_HL;
        end else if (isJr || isJrCc) begin
          st.commitPc = 1'b1;
          st.pcSel    = (isJr || condOk) ? PC_REL : PC_SKIP1;
        end else if (isCall || (isCallCc && condOk)) begin
          callNext  = 1'b1;
          nextState = S_WR1;
        end else if (isCallCc) begin
          st.commitPc = 1'b1;
          st.pcSel    = PC_SKIP2;
        end else if (isPush) begin
          callNext  = 1'b0;
          nextState = S_WR1;
        end else if (isPop) begin
          nextState = S_RD1;
        end else begin
          st.commitPc = 1'b1;
          st.imeClr   = isDi;
          st.imeSet   = isEi;
        end
      end
      S_WR1: begin
        st.memWr   = 1'b1;
        st.adSel   = AD_SPM1;
        st.wrHi    = 1'b1;
        st.pushRet = callQ;
        nextState  = S_WR2;
      end
      S_WR2: begin
        st.memWr    = 1'b1;
        st.adSel    = AD_SPM2;
        st.pushRet  = callQ;
        st.commitPc = 1'b1;
        st.pcSel    = callQ ? PC_ABS : PC_HOLD;
        st.spDown   = 1'b1;
        nextState   = S_IDLE;
      end
      S_RD1: begin
        st.memRd  = 1'b1;
        st.adSel  = AD_SP;
        st.capLo  = 1'b1;
        nextState = S_RD2;
      end
      S_RD2: begin
        st.memRd    = 1'b1;
        st.adSel    = AD_SPP1;
        st.capHi    = 1'b1;
        st.commitPc = 1'b1;
        st.spUp     = 1'b1;
        nextState   = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      callQ <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      callQ <= callNext;
      done  <= st.commitPc;
    end
  end
endmodule

// File: rtl/fcDatapath.sv
`timescale 1ns/1ps
module fcDatapath
  import fcPkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctrlStrobeT     st,
  input  logic [OPW-1:0] opcode,
  input  logic [DW-1:0]  operandLo,
  input  logic [DW-1:0]  operandHi,
  input  logic [AW-1:0]  pcIn,
  input  logic [AW-1:0]  spIn,
  input  logic [AW-1:0]  hlIn,
  input  logic [2*DW-1:0] pairIn,
  input  logic           flagZ,
  input  logic           flagC,
  input  logic [DW-1:0]  memRdata,
  output logic [OPW-1:0] opQ,
  output logic           zQ,
  output logic           cQ,
  output logic [AW-1:0]  pcOut,
  output logic [AW-1:0]  spOut,
  output logic [2*DW-1:0] pairOut,
  output logic           ime,
  output logic           memWe,
  output logic           memRe,
  output logic [AW-1:0]  memAddr,
  output logic [DW-1:0]  memWdata
);
  localparam int PW = 2 * DW;
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [AW-1:0] TWO = AW'(2);

  logic [DW-1:0] loQ, hiQ, popLoQ;
  logic [AW-1:0] pcQ, spQ, hlQ;
  logic [PW-1:0] pairQ;
  logic [AW-1:0] pcNext, spNext, relOff;
  logic [PW-1:0] wordSrc;

  always_comb begin
    relOff = {{(AW-DW){loQ[DW-1]}}, loQ};
    case (st.pcSel)
      PC_SKIP1: pcNext = pcQ + ONE;
      PC_SKIP2: pcNext = pcQ + TWO;
      PC_ABS:   pcNext = AW'({hiQ, loQ});
      PC_HL:    pcNext = hlQ;
      PC_REL:   pcNext = pcQ + ONE + relOff;
      default:  pcNext = pcQ;
    endcase
    if (st.spDown)    spNext = spQ - TWO;
    else if (st.spUp) spNext = spQ + TWO;
    else              spNext = spQ;
    case (st.adSel)
      AD_SPM1: memAddr = spQ - ONE;
      AD_SPM2: memAddr = spQ - TWO;
      AD_SPP1: memAddr = spQ + ONE;
      default: memAddr = spQ;
    endcase
    wordSrc  = st.pushRet ? PW'(pcQ + TWO) : pairQ;
    memWdata = st.wrHi ? wordSrc[PW-1:DW] : wordSrc[DW-1:0];
    memWe    = st.memWr;
    memRe    = st.memRd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= '0; loQ <= '0; hiQ <= '0; zQ <= 1'b0; cQ <= 1'b0;
      pcQ <= '0; spQ <= '0; hlQ <= '0; pairQ <= '0; popLoQ <= '0;
    end else begin
      if (st.latchIn) begin
        opQ <= opcode; loQ <= operandLo; hiQ <= operandHi;
        zQ <= flagZ; cQ <= flagC;
        pcQ <= pcIn; spQ <= spIn; hlQ <= hlIn; pairQ <= pairIn;
      end
      if (st.capLo) popLoQ <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcOut   <= '0;
      spOut   <= '0;
      pairOut <= '0;
      ime     <= 1'b1;
    end else begin
      if (st.commitPc) begin
        pcOut <= pcNext;
        spOut <= spNext;
      end
      if (st.capHi)  pairOut <= {memRdata, popLoQ};
      if (st.imeClr) ime <= 1'b0;
      else if (st.imeSet) ime <= 1'b1;
    end
  end
endmodule

// File: rtl/flowCtrlUnit.sv
`timescale 1ns/1ps
module flowCtrlUnit
  import fcPkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OPW-1:0]  opcode,
  input  logic [DW-1:0]   operandLo,
  input  logic [DW-1:0]   operandHi,
  input  logic [AW-1:0]   pcIn,
  input  logic [AW-1:0]   spIn,
  input  logic [AW-1:0]   hlIn,
  input  logic [2*DW-1:0] pairIn,
  input  logic            flagZ,
  input  logic            flagC,
  input  logic [DW-1:0]   memRdata,
  output logic            done,
  output logic [AW-1:0]   pcOut,
  output logic [AW-1:0]   spOut,
  output logic [2*DW-1:0] pairOut,
  output logic            ime,
  output logic            memWe,
  output logic            memRe,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata
);
  ctrlStrobeT     st;
  logic [OPW-1:0] opQ;
  logic           zQ, cQ;

  fcControl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opQ(opQ), .zQ(zQ), .cQ(cQ),
    .st(st), .done(done)
  );

  fcDatapath #(.AW(AW), .DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .opcode(opcode),
    .operandLo(operandLo), .operandHi(operandHi), .pcIn(pcIn), .spIn(spIn),
    .hlIn(hlIn), .pairIn(pairIn), .flagZ(flagZ), .flagC(flagC),
    .memRdata(memRdata), .opQ(opQ), .zQ(zQ), .cQ(cQ), .pcOut(pcOut),
    .spOut(spOut), .pairOut(pairOut), .ime(ime), .memWe(memWe), .memRe(memRe),
    .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/fcChecker.sv
`timescale 1ns/1ps
module fcChecker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          done,
  input logic          memWe,
  input logic          memRe,
  input logic [AW-1:0] memAddr,
  input logic [AW-1:0] pcOut,
  input logic [AW-1:0] spOut,
  input logic          ime
);
  localparam logic [AW-1:0] ONE = AW'(1);

  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(memWe && memRe)); // R6
  AST_WR_DESCEND: assert property (@(posedge clk) disable iff (!rstN) memWe && $past(memWe) |-> memAddr == $past(memAddr) - ONE); // R6
  AST_WR_THEN_DONE: assert property (@(posedge clk) disable iff (!rstN) memWe && $past(memWe) |=> done && !memWe); // R6
  AST_SP_PUSHED: assert property (@(posedge clk) disable iff (!rstN) done && $past(memWe) |-> spOut == $past(memAddr)); // R8
  AST_RD_ASCEND: assert property (@(posedge clk) disable iff (!rstN) memRe && $past(memRe) |-> memAddr == $past(memAddr) + ONE); // R9
  AST_SP_POPPED: assert property (@(posedge clk) disable iff (!rstN) done && $past(memRe) |-> spOut == $past(memAddr) + ONE); // R9
  AST_IME_HOLD: assert property (@(posedge clk) disable iff (!rstN) !done |-> $stable(ime)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R12
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rstN) !done |-> $stable(pcOut) && $stable(spOut)); // R12
endmodule

bind flowCtrlUnit fcChecker #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .done(done), .memWe(memWe), .memRe(memRe),
  .memAddr(memAddr), .pcOut(pcOut), .spOut(spOut), .ime(ime)
);

// File: tb/tb_flowCtrlUnit.sv
`timescale 1ns/1ps
module tb_flowCtrlUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = '0, operandLo = '0, operandHi = '0;
  logic [15:0] pcIn = '0, spIn = '0, hlIn = '0, pairIn = '0;
  logic flagZ = 1'b0, flagC = 1'b0;
  logic [7:0] memRdata;
  logic done, ime, memWe, memRe;
  logic [15:0] pcOut, spOut, pairOut, memAddr;
  logic [7:0] memWdata;

  logic [7:0] mem [256];
  assign memRdata = mem[memAddr[7:0]];

  always #2.5 clk = ~clk;

  flowCtrlUnit dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .operandLo(operandLo), .operandHi(operandHi), .pcIn(pcIn), .spIn(spIn),
    .hlIn(hlIn), .pairIn(pairIn), .flagZ(flagZ), .flagC(flagC),
    .memRdata(memRdata), .done(done), .pcOut(pcOut), .spOut(spOut),
    .pairOut(pairOut), .ime(ime), .memWe(memWe), .memRe(memRe),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  int total = 0;
  int bad = 0;
  int lat;
  int nWr, nRd;
  logic [15:0] wrA [4];
  logic [7:0]  wrD [4];
  logic [15:0] rdA [4];

  typedef struct packed {
    logic [7:0]  op;
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic        z;
    logic        c;
    logic [15:0] pc;
    logic [15:0] sp;
    logic [15:0] hl;
    logic [15:0] pair;
    logic [15:0] expPc;
    logic [15:0] expSp;
    logic [3:0]  expLat;
    logic [1:0]  expWr;
    logic [3:0]  req;
  } vecT;

  localparam int NV = 20;
  localparam vecT VECS [NV] = '{
    '{8'hC3, 8'h78, 8'h56, 1'b0, 1'b0, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h5678, 16'hC000, 4'd2, 2'd0, 4'd2},  // R2
    '{8'hC2, 8'h78, 8'h56, 1'b0, 1'b0, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h5678, 16'hC000, 4'd2, 2'd0, 4'd3},  // R3 NZ taken
    '{8'hC2, 8'h78, 8'h56, 1'b1, 1'b0, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h1236, 16'hC000, 4'd2, 2'd0, 4'd3},  // R3 NZ skip
    '{8'hCA, 8'h78, 8'h56, 1'b1, 1'b0, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h5678, 16'hC000, 4'd2, 2'd0, 4'd3},  // R3 Z taken
    '{8'hD2, 8'h78, 8'h56, 1'b0, 1'b1, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h1236, 16'hC000, 4'd2, 2'd0, 4'd3},  // R3 NC skip
    '{8'hDA, 8'h78, 8'h56, 1'b0, 1'b1, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h5678, 16'hC000, 4'd2, 2'd0, 4'd3},  // R3 C taken
    '{8'hE9, 8'h00, 8'h00, 1'b0, 1'b0, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h4567, 16'hC000, 4'd2, 2'd0, 4'd4},  // R4
    '{8'h18, 8'h10, 8'h00, 1'b1, 1'b1, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h1245, 16'hC000, 4'd2, 2'd0, 4'd5},  // R5
    '{8'h20, 8'hF0, 8'h00, 1'b0, 1'b0, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h1225, 16'hC000, 4'd2, 2'd0, 4'd5},  // R5 backward
    '{8'h28, 8'hF0, 8'h00, 1'b0, 1'b0, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h1235, 16'hC000, 4'd2, 2'd0, 4'd5},  // R5 skip
    '{8'h38, 8'h80, 8'h00, 1'b0, 1'b1, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h11B5, 16'hC000, 4'd2, 2'd0, 4'd5},  // R5 -128
    '{8'h30, 8'h80, 8'h00, 1'b0, 1'b1, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h1235, 16'hC000, 4'd2, 2'd0, 4'd5},  // R5 skip
    '{8'hC4, 8'h78, 8'h56, 1'b1, 1'b0, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h1236, 16'hC000, 4'd2, 2'd0, 4'd7},  // R7
    '{8'hCD, 8'h78, 8'h56, 1'b0, 1'b0, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h5678, 16'hBFFE, 4'd4, 2'd2, 4'd6},  // R6
    '{8'hDC, 8'h78, 8'h56, 1'b0, 1'b1, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h5678, 16'hBFFE, 4'd4, 2'd2, 4'd6},  // R6 C taken
    '{8'hC5, 8'h00, 8'h00, 1'b0, 1'b0, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h1234, 16'hBFFE, 4'd4, 2'd2, 4'd8},  // R8
    '{8'h00, 8'h78, 8'h56, 1'b0, 1'b0, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF, 16'h1234, 16'hC000, 4'd2, 2'd0, 4'd12}, // R12 unknown
    '{8'h18, 8'h05, 8'h00, 1'b0, 1'b0, 16'hFFFF, 16'hC000, 16'h4567, 16'hBEEF, 16'h0005, 16'hC000, 4'd2, 2'd0, 4'd11}, // R11
    '{8'hC2, 8'h00, 8'h00, 1'b1, 1'b0, 16'hFFFF, 16'hC000, 16'h4567, 16'hBEEF, 16'h0001, 16'hC000, 4'd2, 2'd0, 4'd11}, // R11
    '{8'hCD, 8'h00, 8'h20, 1'b0, 1'b0, 16'hFFFE, 16'h0001, 16'h4567, 16'hBEEF, 16'h2000, 16'hFFFF, 4'd4, 2'd2, 4'd11}  // R11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setOp(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi,
                       input logic z, input logic c, input logic [15:0] pc,
                       input logic [15:0] sp, input logic [15:0] hl, input logic [15:0] pr);
    opcode = op; operandLo = lo; operandHi = hi; flagZ = z; flagC = c;
    pcIn = pc; spIn = sp; hlIn = hl; pairIn = pr;
  endtask

  // Called at a falling edge; pulses start and waits for done, logging memory traffic.
  task automatic runOp();
    start = 1'b1;
    lat = 0; nWr = 0; nRd = 0;
    while (lat < 20) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
      if (memWe && nWr < 4) begin wrA[nWr] = memAddr; wrD[nWr] = memWdata; nWr++; end
      if (memRe && nRd < 4) begin rdA[nRd] = memAddr; nRd++; end
      if (done) break;
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 pc", 32'(pcOut), 32'h0);
    chk("R1 sp", 32'(spOut), 32'h0);
    chk("R1 pair", 32'(pairOut), 32'h0);
    chk("R1 ime", 32'(ime), 32'h1);
    chk("R1 idle", {29'd0, done, memWe, memRe}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      setOp(VECS[i].op, VECS[i].lo, VECS[i].hi, VECS[i].z, VECS[i].c,
            VECS[i].pc, VECS[i].sp, VECS[i].hl, VECS[i].pair);
      runOp();
      chk($sformatf("R%0d pc vec%0d", VECS[i].req, i), 32'(pcOut), 32'(VECS[i].expPc));
      chk($sformatf("R%0d sp vec%0d", VECS[i].req, i), 32'(spOut), 32'(VECS[i].expSp));
      chk($sformatf("R%0d latency vec%0d", VECS[i].req, i), 32'(lat), 32'(VECS[i].expLat));
      chk($sformatf("R%0d writes vec%0d", VECS[i].req, i), 32'(nWr), 32'(VECS[i].expWr));
      @(negedge clk);
    end

    // R6 call: return address 0x1236, high byte at sp-1 first
    setOp(8'hCD, 8'h78, 8'h56, 1'b0, 1'b0, 16'h1234, 16'hC000, 16'h4567, 16'hBEEF);
    runOp();
    chk("R6 wr0 addr", 32'(wrA[0]), 32'hBFFF);
    chk("R6 wr0 data", 32'(wrD[0]), 32'h12);
    chk("R6 wr1 addr", 32'(wrA[1]), 32'hBFFE);
    chk("R6 wr1 data", 32'(wrD[1]), 32'h36);
    @(negedge clk);

    // R8 push of 0xBEEF
    setOp(8'hE5, 8'h00, 8'h00, 1'b0, 1'b0, 16'h2000, 16'hD000, 16'h0, 16'hBEEF);
    runOp();
    chk("R8 wr0", {wrA[0], 8'h0, wrD[0]}, {16'hCFFF, 8'h0, 8'hBE});
    chk("R8 wr1", {wrA[1], 8'h0, wrD[1]}, {16'hCFFE, 8'h0, 8'hEF});
    chk("R8 pc", 32'(pcOut), 32'h2000);
    @(negedge clk);

    // R11 call wrapping the stack through zero
    setOp(8'hCD, 8'h00, 8'h20, 1'b0, 1'b0, 16'hFFFE, 16'h0001, 16'h0, 16'h0);
    runOp();
    chk("R11 wr0 addr", 32'(wrA[0]), 32'h0000);
    chk("R11 wr1 addr", 32'(wrA[1]), 32'hFFFF);
    chk("R11 ret lo", 32'(wrD[1]), 32'h00);
    @(negedge clk);

    // R9 pop: low at sp, high at sp+1
    mem[8'h10] = 8'h3C; mem[8'h11] = 8'hA5;
    setOp(8'hD1, 8'h00, 8'h00, 1'b0, 1'b0, 16'h3000, 16'hC010, 16'h0, 16'h0);
    runOp();
    chk("R9 pair", 32'(pairOut), 32'hA53C);
    chk("R9 sp", 32'(spOut), 32'hC012);
    chk("R9 rd order", {rdA[0], rdA[1]}, {16'hC010, 16'hC011});
    chk("R9 no write", 32'(nWr), 32'h0);
    chk("R9 latency", 32'(lat), 32'd4);
    @(negedge clk);

    // R11 pop wrapping
    mem[8'hFF] = 8'h11; mem[8'h00] = 8'h22;
    setOp(8'hF1, 8'h00, 8'h00, 1'b0, 1'b0, 16'h3000, 16'hFFFF, 16'h0, 16'h0);
    runOp();
    chk("R11 pop pair", 32'(pairOut), 32'h2211);
    chk("R11 pop sp", 32'(spOut), 32'h0001);
    @(negedge clk);

    // R10 interrupt enable control
    setOp(8'hF3, 8'h00, 8'h00, 1'b0, 1'b0, 16'h1000, 16'hC000, 16'h0, 16'h0);
    runOp();
    chk("R10 ime cleared", 32'(ime), 32'h0);
    @(negedge clk);
    setOp(8'hFB, 8'h00, 8'h00, 1'b0, 1'b0, 16'h1000, 16'hC000, 16'h0, 16'h0);
    runOp();
    chk("R10 ime set", 32'(ime), 32'h1);
    @(negedge clk);

    // R12 start while busy is ignored
    setOp(8'hC5, 8'h00, 8'h00, 1'b0, 1'b0, 16'h4444, 16'hC000, 16'h0, 16'h1234);
    start = 1'b1;
    @(negedge clk);
    setOp(8'hC3, 8'h78, 8'h56, 1'b0, 1'b0, 16'h9999, 16'h8000, 16'h0, 16'h0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 busy done", 32'(done), 32'h1);
    chk("R12 busy pc", 32'(pcOut), 32'h4444);
    chk("R12 busy sp", 32'(spOut), 32'hBFFE);
    repeat (3) @(negedge clk);
    chk("R12 hold pc", 32'(pcOut), 32'h4444);
    chk("R12 done low", 32'(done), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule